// File: doc/BRIEF.md
# External Data Space Region Decoder

This block sits between a small processor's 16-bit external bus and the on-chip resources that share that address space. For every access it names one target. The target is either a block of configuration storage that starts at address zero, a 256-byte probe window that follows straight after that storage, a 256-byte auxiliary RAM at the top of the space, or the external bus. The external bus takes any address that no enabled on-chip target claims. The auxiliary RAM is part of the block, so writes to it are stored here and reads return its bytes.

The size of the configuration region follows a two-bit array-size setting, and the probe window moves with it. Each on-chip region has its own enable. Software may change the enables and the size between any two accesses, and the next access follows the new setting without a reset. Accesses are either data accesses or program fetches. The auxiliary RAM answers both kinds. The configuration region answers fetches only when a separate fetch bit is set, and the probe window never answers fetches.

Top module: `xdata_region_decoder`

## Requirements
- R1: While reset is high, and on the first output cycle after it, all four hit outputs, `out_addr` and `aux_rdata` are zero.
- R2: The configuration region spans 0x0000 up to a limit set by `array_size`: 0→0x1000, 1→0x1800, 2→0x3000, 3→0x4000. A data access below the limit with `map_cfg_en` set raises `hit_cfg`, and `out_addr` carries the address unchanged.
- R3: A data access from the limit to limit+0xFF with `map_probe_en` set raises `hit_probe`, and `out_addr` carries the address minus the limit (0x00–0xFF).
- R4: An access, data or fetch, to 0xFF00–0xFFFF with `map_aux_en` set raises `hit_aux`, and `out_addr` carries the low address byte.
- R5: An access that no enabled region claims raises `hit_ext`, and `out_addr` carries the full address. This includes accesses to a disabled region and to the space between the probe window and 0xFF00.
- R6: A fetch to the configuration region hits it only when both `map_cfg_en` and `cfg_fetch_en` are set, and goes external otherwise. A fetch to the probe window always goes external.
- R7: Each result appears on the cycle after the request. A valid request gives exactly one of the four hits. A cycle without a request gives no hit and `out_addr` = 0.
- R8: A data write that hits the auxiliary RAM stores `req_wdata`. A read that hits it, data or fetch, returns the stored byte on `aux_rdata` in the same cycle as `hit_aux`. At every other time `aux_rdata` is 0.
- R9: A write to 0xFF00–0xFFFF while `map_aux_en` is clear goes external and leaves the RAM contents unchanged.
- R10: A change of enables or size between two back-to-back accesses applies to the second access, with no reset.
- R11: A request with both `req_fetch` and `req_write` set is treated as a read, and the RAM byte it addresses is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_addr | input | 16 | Access address |
| req_fetch | input | 1 | 1 = program fetch, 0 = data access |
| req_write | input | 1 | 1 = data write |
| req_wdata | input | 8 | Write data |
| map_cfg_en | input | 1 | Enable the configuration region |
| map_probe_en | input | 1 | Enable the probe window |
| map_aux_en | input | 1 | Enable the auxiliary RAM |
| cfg_fetch_en | input | 1 | Let the configuration region answer fetches |
| array_size | input | 2 | Selects the configuration region limit |
| hit_cfg | output | 1 | Access claimed by the configuration region |
| hit_probe | output | 1 | Access claimed by the probe window |
| hit_aux | output | 1 | Access claimed by the auxiliary RAM |
| hit_ext | output | 1 | Access passed to the external bus |
| out_addr | output | 16 | Offset inside the claimed region, or the full address for external |
| aux_rdata | output | 8 | Auxiliary RAM read data |

## Verification
Every output belongs to the request captured at one rising edge, so each hit, `out_addr` and `aux_rdata` is due exactly one cycle after the stimulus. The bench drives inputs just after a rising edge and computes its expectation at the next rising edge from the inputs the design sees there. It compares at the falling edge that follows, when the registered results have settled. Back-to-back requests with enable changes in between check that no result leaks into the next cycle. An auxiliary write followed at once by a read of the same byte checks that the stored value is ready one cycle later.

// File: rtl/xdr_pkg.sv
package xdr_pkg;

    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 8;
    localparam int PAGE_W     = 8;
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int SIZE_W     = 2;
    localparam int KBYTE      = 1024;
    localparam int N_TGT      = 4;

    typedef enum logic [1:0] {
        TGT_EXT   = 2'd0,
        TGT_CFG   = 2'd1,
        TGT_PROBE = 2'd2,
        TGT_AUX   = 2'd3
    } tgt_e;

    typedef struct packed {
        tgt_e              tgt;
        logic [ADDR_W-1:0] ofs;
        logic              wr;
    } route_t;

    // Top of the configuration region (exclusive) for each array size
    function automatic logic [ADDR_W-1:0] cfg_span(input logic [SIZE_W-1:0] sz);
        logic [ADDR_W-1:0] s;
        case (sz)
            2'd0:    s = ADDR_W'(4  * KBYTE);
            2'd1:    s = ADDR_W'(6  * KBYTE);
            2'd2:    s = ADDR_W'(12 * KBYTE);
            default: s = ADDR_W'(16 * KBYTE);
        endcase
        return s;
    endfunction

endpackage

// File: rtl/xdr_route_decode.sv
module xdr_route_decode
    import xdr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              fetch,
    input  logic              write,
    input  logic              cfg_en,
    input  logic              probe_en,
    input  logic              aux_en,
    input  logic              fetch_en,
    input  logic [SIZE_W-1:0] size,
    output route_t            route
);

    logic [ADDR_W-1:0] limit;
    logic [ADDR_W-1:0] probe_end;
    logic              in_cfg;
    logic              in_probe;
    logic              in_aux;

    always_comb begin
        limit     = cfg_span(size);
        probe_end = limit + ADDR_W'(PAGE_BYTES);
        in_cfg    = addr < limit;
        in_probe  = (addr >= limit) && (addr < probe_end);
        in_aux    = &addr[ADDR_W-1:PAGE_W];
    end

    always_comb begin
        route.tgt = TGT_EXT;
        route.ofs = addr;
        route.wr  = write && !fetch;
        if (aux_en && in_aux) begin
            route.tgt = TGT_AUX;
            route.ofs = {{(ADDR_W-PAGE_W){1'b0}}, addr[PAGE_W-1:0]};
        end else if (cfg_en && in_cfg && (!fetch || fetch_en)) begin
            route.tgt = TGT_CFG;
            route.ofs = addr;
        end else if (probe_en && in_probe && !fetch) begin
            route.tgt = TGT_PROBE;
            route.ofs = addr - limit;
        end
    end

endmodule

// File: rtl/xdr_aux_ram.sv
module xdr_aux_ram #(
    parameter int DW    = 8,
    parameter int IDX_W = 8,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic             re,
    input  logic [IDX_W-1:0] idx,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[idx] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= mem[idx];
        end else begin
            rdata <= '0;
        end
    end

endmodule

// File: rtl/xdata_region_decoder.sv
module xdata_region_decoder
    import xdr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [15:0]       req_addr,
    input  logic              req_fetch,
    input  logic              req_write,
    input  logic [7:0]        req_wdata,
    input  logic              map_cfg_en,
    input  logic              map_probe_en,
    input  logic              map_aux_en,
    input  logic              cfg_fetch_en,
    input  logic [1:0]        array_size,
    output logic              hit_cfg,
    output logic              hit_probe,
    output logic              hit_aux,
    output logic              hit_ext,
    output logic [15:0]       out_addr,
    output logic [7:0]        aux_rdata
);

    route_t            route_d;
    route_t            route_q;
    logic              valid_q;
    logic [N_TGT-1:0]  hit_vec;
    logic              aux_sel;

    xdr_route_decode u_decode (
        .addr     (req_addr),
        .fetch    (req_fetch),
        .write    (req_write),
        .cfg_en   (map_cfg_en),
        .probe_en (map_probe_en),
        .aux_en   (map_aux_en),
        .fetch_en (cfg_fetch_en),
        .size     (array_size),
        .route    (route_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            route_q <= '0;
        end else begin
            valid_q <= req_valid;
            route_q <= req_valid ? route_d : '0;
        end
    end

    assign aux_sel = req_valid && (route_d.tgt == TGT_AUX);

    xdr_aux_ram #(
        .DW    (DATA_W),
        .IDX_W (PAGE_W)
    ) u_aux (
        .clk   (clk),
        .rst   (rst),
        .we    (aux_sel && route_d.wr),
        .re    (aux_sel && !route_d.wr),
        .idx   (req_addr[PAGE_W-1:0]),
        .wdata (req_wdata),
        .rdata (aux_rdata)
    );

    for (genvar g = 0; g < N_TGT; g++) begin : g_hit
        assign hit_vec[g] = valid_q && (route_q.tgt == tgt_e'(g));
    end

    assign hit_ext   = hit_vec[TGT_EXT];
    assign hit_cfg   = hit_vec[TGT_CFG];
    assign hit_probe = hit_vec[TGT_PROBE];
    assign hit_aux   = hit_vec[TGT_AUX];
    assign out_addr  = route_q.ofs;

endmodule

// File: rtl/xdr_checker.sv
module xdr_checker (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [15:0] req_addr,
    input logic        req_fetch,
    input logic        map_cfg_en,
    input logic        map_aux_en,
    input logic        hit_cfg,
    input logic        hit_probe,
    input logic        hit_aux,
    input logic        hit_ext,
    input logic [15:0] out_addr,
    input logic [7:0]  aux_rdata
);

    // R7
    one_hit_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> $countones({hit_cfg, hit_probe, hit_aux, hit_ext}) == 1);

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ({hit_cfg, hit_probe, hit_aux, hit_ext} == 4'b0) && (out_addr == 16'h0));

    // R4
    aux_claim_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && map_aux_en && (req_addr[15:8] == 8'hFF))
        |=> hit_aux && (out_addr == {8'h00, $past(req_addr[7:0])}));

    // R6
    fetch_no_probe_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_fetch) |=> !hit_probe);

    // R2
    cfg_floor_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_fetch && map_cfg_en && (req_addr < 16'h1000))
        |=> hit_cfg && (out_addr == $past(req_addr)));

    // R8
    rdata_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !hit_aux |-> (aux_rdata == 8'h00));

endmodule

bind xdata_region_decoder xdr_checker i_xdr_checker (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_fetch  (req_fetch),
    .map_cfg_en (map_cfg_en),
    .map_aux_en (map_aux_en),
    .hit_cfg    (hit_cfg),
    .hit_probe  (hit_probe),
    .hit_aux    (hit_aux),
    .hit_ext    (hit_ext),
    .out_addr   (out_addr),
    .aux_rdata  (aux_rdata)
);

// File: tb/test_xdata_region_decoder.sv
`timescale 1ns/1ps
module test_xdata_region_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_fetch = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_wdata = '0;
    logic        map_cfg_en = 1'b0;
    logic        map_probe_en = 1'b0;
    logic        map_aux_en = 1'b0;
    logic        cfg_fetch_en = 1'b0;
    logic [1:0]  array_size = '0;
    logic        hit_cfg, hit_probe, hit_aux, hit_ext;
    logic [15:0] out_addr;
    logic [7:0]  aux_rdata;

    int n_run = 0;
    int n_fail = 0;
    string cur_tag = "R1";

    xdata_region_decoder i_xdata_region_decoder (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_fetch(req_fetch), .req_write(req_write), .req_wdata(req_wdata),
        .map_cfg_en(map_cfg_en), .map_probe_en(map_probe_en),
        .map_aux_en(map_aux_en), .cfg_fetch_en(cfg_fetch_en),
        .array_size(array_size), .hit_cfg(hit_cfg), .hit_probe(hit_probe),
        .hit_aux(hit_aux), .hit_ext(hit_ext), .out_addr(out_addr),
        .aux_rdata(aux_rdata)
    );

    always #4 clk = ~clk;

    // ---------------- reference model ----------------
    int          ref_mem [256];
    logic [3:0]  exp_hits = 4'b0;   // {aux, probe, cfg, ext}
    logic [15:0] exp_addr = '0;
    logic [7:0]  exp_rdata = '0;
    string       exp_tag = "R1";

    function automatic int size_limit(input int sz);
        if (sz == 0) return 4096;
        if (sz == 1) return 6144;
        if (sz == 2) return 12288;
        return 16384;
    endfunction

    always @(posedge clk) begin
        int a, lim;
        exp_tag   = cur_tag;
        exp_hits  = 4'b0;
        exp_addr  = '0;
        exp_rdata = '0;
        if (rst) begin
            exp_tag = "R1";
        end else if (req_valid) begin
            a   = int'(req_addr);
            lim = size_limit(int'(array_size));
            if (map_aux_en && a >= 65280) begin
                exp_hits = 4'b1000;
                exp_addr = 16'(a - 65280);
                if (req_write && !req_fetch) ref_mem[a - 65280] = int'(req_wdata);
                else exp_rdata = 8'(ref_mem[a - 65280]);
            end else if (map_cfg_en && a < lim && (!req_fetch || cfg_fetch_en)) begin
                exp_hits = 4'b0010;
                exp_addr = 16'(a);
            end else if (map_probe_en && !req_fetch && a >= lim && a < lim + 256) begin
                exp_hits = 4'b0100;
                exp_addr = 16'(a - lim);
            end else begin
                exp_hits = 4'b0001;
                exp_addr = 16'(a);
            end
        end
    end

    always @(negedge clk) begin
        logic [3:0] act;
        act = {hit_aux, hit_probe, hit_cfg, hit_ext};
        n_run++;
        if (act !== exp_hits) begin
            n_fail++;
            $display("FAIL %s hits {aux,probe,cfg,ext} actual=%b expected=%b", exp_tag, act, exp_hits);
        end
        n_run++;
        if (out_addr !== exp_addr) begin
            n_fail++;
            $display("FAIL %s out_addr actual=%h expected=%h", exp_tag, out_addr, exp_addr);
        end
        n_run++;
        if (aux_rdata !== exp_rdata) begin
            n_fail++;
            $display("FAIL %s aux_rdata actual=%h expected=%h", exp_tag, aux_rdata, exp_rdata);
        end
    end

    // ---------------- stimulus ----------------
    task automatic acc(input logic [15:0] a, input bit f, input bit w, input logic [7:0] d);
        req_valid = 1'b1; req_addr = a; req_fetch = f; req_write = w; req_wdata = d;
        @(posedge clk); #1;
        req_valid = 1'b0; req_write = 1'b0; req_fetch = 1'b0;
    endtask

    task automatic idle(input int n);
        req_valid = 1'b0;
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic set_map(input bit c, input bit p, input bit x, input bit fe, input logic [1:0] sz);
        map_cfg_en = c; map_probe_en = p; map_aux_en = x; cfg_fetch_en = fe; array_size = sz;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) ref_mem[i] = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R2 / R3: every size, edges of both regions
        for (int s = 0; s < 4; s++) begin
            int lim;
            lim = size_limit(s);
            set_map(1, 1, 0, 0, 2'(s));
            cur_tag = "R2";
            acc(16'h0000, 0, 0, 0);
            acc(16'(lim - 1), 0, 1, 8'h11);
            cur_tag = "R3";
            acc(16'(lim), 0, 0, 0);
            acc(16'(lim + 255), 0, 0, 0);
            cur_tag = "R5";
            acc(16'(lim + 256), 0, 0, 0);
        end

        // R5: disabled regions fall through
        cur_tag = "R5";
        set_map(0, 0, 0, 0, 2'd1);
        acc(16'h0000, 0, 0, 0);
        acc(16'h1800, 0, 0, 0);
        acc(16'hFF00, 0, 0, 0);
        acc(16'h8000, 0, 0, 0);

        // R8: fill the RAM, read back by data and by fetch
        cur_tag = "R8";
        set_map(0, 0, 1, 0, 2'd0);
        for (int i = 0; i < 256; i++) acc(16'hFF00 + 16'(i), 0, 1, 8'(i * 7 + 3));
        acc(16'hFF05, 0, 0, 0);
        acc(16'hFFFF, 1, 0, 0);
        acc(16'hFF40, 0, 1, 8'hC3);
        acc(16'hFF40, 0, 0, 0);
        idle(1);

        // R4: aux claims data and fetch at both ends
        cur_tag = "R4";
        acc(16'hFF00, 1, 0, 0);
        acc(16'hFFFF, 0, 0, 0);

        // R9: write while aux disabled leaves RAM alone
        cur_tag = "R9";
        set_map(0, 0, 0, 0, 2'd0);
        acc(16'hFF10, 0, 1, 8'h5A);
        set_map(0, 0, 1, 0, 2'd0);
        acc(16'hFF10, 0, 0, 0);

        // R11: fetch with write flag is only a read
        cur_tag = "R11";
        acc(16'hFF20, 1, 1, 8'h77);
        acc(16'hFF20, 0, 0, 0);

        // R6: fetch into cfg needs fetch enable; probe never takes fetches
        cur_tag = "R6";
        set_map(1, 1, 0, 0, 2'd2);
        acc(16'h0100, 1, 0, 0);
        acc(16'h3000, 1, 0, 0);
        set_map(1, 1, 0, 1, 2'd2);
        acc(16'h0100, 1, 0, 0);
        acc(16'h2FFF, 1, 0, 0);
        acc(16'h3010, 1, 0, 0);

        // R10: change map between back-to-back accesses
        cur_tag = "R10";
        req_valid = 1'b1; req_addr = 16'h1800; req_fetch = 1'b0; req_write = 1'b0;
        set_map(1, 1, 1, 0, 2'd0);
        @(posedge clk); #1;
        array_size = 2'd1;
        @(posedge clk); #1;
        map_probe_en = 1'b0;
        @(posedge clk); #1;
        array_size = 2'd3;
        @(posedge clk); #1;
        map_cfg_en = 1'b0;
        @(posedge clk); #1;
        req_valid = 1'b0;

        // R7: idle gaps and a mixed sweep
        cur_tag = "R7";
        idle(3);
        for (int k = 0; k < 400; k++) begin
            logic [15:0] a;
            int pick;
            pick = int'($urandom % 4);
            set_map($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2, 2'($urandom % 4));
            if (pick == 0)      a = 16'(size_limit(int'(array_size)) - 2 + int'($urandom % 4));
            else if (pick == 1) a = 16'(size_limit(int'(array_size)) + 254 + int'($urandom % 4));
            else if (pick == 2) a = 16'hFEFE + 16'($urandom % 4);
            else                a = 16'($urandom);
            if ($urandom % 5 == 0) idle(1);
            acc(a, $urandom % 2, $urandom % 2, 8'($urandom));
        end
        idle(3);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R7 watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule